// File: doc/BRIEF.md
# Load Miss Tracking Table

This block sits beside a non-blocking data cache and keeps a record of every load miss that is still waiting for its line. Each entry holds the line address that missed and the destination register tags of the loads that asked for it. A fresh miss takes a free entry and sends one refill request to the next memory level. The request carries the entry number, so the refill can name the entry when it returns.

A later miss to a line that is already being fetched does not go out again. It joins the waiting entry as an extra waiter. When a refill arrives, the entry hands the returned data to each waiting register tag in turn, one per cycle, and then becomes free. Several entries can be waiting at once, so the refills of different lines overlap.

When no entry can take a miss, the block raises a stall flag in the same cycle. The requester must offer that miss again later.

Top module: `missAddrFile`

## Requirements
- R1: During and straight after reset, `stall`, `reqValid` and `outValid` are low and no entry is in use.
- R2: An accepted miss (`missValid` high, `stall` low) whose line matches no waiting entry takes the lowest-numbered free entry. In the next cycle `reqValid` is high, `reqLine` equals the miss line and `reqIdx` is the entry number (0 to ENTRIES-1).
- R3: An accepted miss whose line matches an entry still waiting for its refill sends no request. Its tag is appended to that entry's waiters, up to WAITERS (2) tags per entry.
- R4: `stall` is high in the same cycle as a miss that cannot be taken, and only then. That happens when no entry is free and the line matches no waiting entry, or when the matching waiting entry already holds WAITERS tags. A stalled miss changes nothing.
- R5: All ENTRIES (6) entries can wait at the same time. At most one refill request is issued per cycle.
- R6: A response (`rspValid`, `rspIdx`, `rspData`) to a waiting entry makes `outValid` high from the next cycle. `outTag` gives that entry's tags one per cycle in the order they arrived, with `outData` equal to `rspData`. The entry is free again in the cycle after its last tag.
- R7: When several entries hold returned data, the lowest-numbered one is delivered first.
- R8: A response whose index names an entry that is free, already filled, or out of range (6 or 7) is ignored.
- R9: A miss to a line whose entry is already filled and delivering is not merged. It is treated as a new miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A load miss is offered this cycle |
| missLine | input | LINE_W | Line address of the miss |
| missTag | input | TAG_W | Destination register tag of the load |
| stall | output | 1 | The offered miss is not taken |
| reqValid | output | 1 | Refill request to the next level |
| reqLine | output | LINE_W | Line address requested |
| reqIdx | output | IDX_W | Entry number the refill must return to |
| rspValid | input | 1 | Refill response present |
| rspIdx | input | IDX_W | Entry number of the response |
| rspData | input | DATA_W | Returned data |
| outValid | output | 1 | Data delivered to one register tag |
| outTag | output | TAG_W | Destination register tag being served |
| outData | output | DATA_W | Delivered data |

## Verification
`stall` depends only on the current inputs and the table state, so it is due in the same cycle as the miss. A refill request appears one register later, in the cycle after the miss is accepted. Delivered tags start the cycle after a response and follow one per cycle. A freed entry can be taken again in the cycle after its last tag. The bench drives inputs on the falling edge and compares every output one nanosecond later against a queue-based model. It then advances the model to match the next rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/mafPkg.sv
package mafPkg;

  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_PEND = 2'd1,
    ENT_FILL = 2'd2
  } entState_t;

  typedef struct packed {
    logic alloc;
    logic merge;
    logic fill;
    logic drain;
  } ctrlStrobes_t;

endpackage

// File: rtl/mafControl.sv
module mafControl
  import mafPkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int WAITERS = 2,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               missValid,
  input  logic [ENTRIES-1:0] lineHit,
  input  logic               rspValid,
  input  logic [IDX_W-1:0]   rspIdx,
  output ctrlStrobes_t       strb,
  output logic [IDX_W-1:0]   allocIdx,
  output logic [IDX_W-1:0]   mergeIdx,
  output logic [CNT_W-1:0]   mergeSlot,
  output logic [IDX_W-1:0]   fillIdx,
  output logic [IDX_W-1:0]   drainIdx,
  output logic [CNT_W-1:0]   drainSlot,
  output logic               stall,
  output logic               outValid
);

  entState_t        stQ   [ENTRIES];
  logic [CNT_W-1:0] cntQ  [ENTRIES];
  logic [CNT_W-1:0] doneQ [ENTRIES];

  logic [ENTRIES-1:0] pendVec, freeVec, fullVec, hitVec;
  logic               hitAny, freeAny, fillAny, hitFull, fillOk, drainLast;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      pendVec[i] = (stQ[i] == ENT_PEND);
      freeVec[i] = (stQ[i] == ENT_FREE);
      fullVec[i] = (stQ[i] == ENT_FILL);
    end
    hitVec  = lineHit & pendVec;
    hitAny  = |hitVec;
    freeAny = |freeVec;
    fillAny = |fullVec;

    mergeIdx = '0;
    allocIdx = '0;
    drainIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i])  mergeIdx = IDX_W'(i);
      if (freeVec[i]) allocIdx = IDX_W'(i);
      if (fullVec[i]) drainIdx = IDX_W'(i);
    end

    fillOk = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rspIdx == IDX_W'(i) && pendVec[i]) fillOk = 1'b1;
    end

    hitFull   = (cntQ[mergeIdx] == CNT_W'(WAITERS));
    mergeSlot = cntQ[mergeIdx];
    drainSlot = doneQ[drainIdx];
    drainLast = ((doneQ[drainIdx] + CNT_W'(1)) == cntQ[drainIdx]);
    fillIdx   = rspIdx;

    stall      = missValid && (hitAny ? hitFull : !freeAny);
    strb.merge = missValid && hitAny && !hitFull;
    strb.alloc = missValid && !hitAny && freeAny;
    strb.fill  = rspValid && fillOk;
    strb.drain = fillAny;
    outValid   = fillAny;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        stQ[i]   <= ENT_FREE;
        cntQ[i]  <= '0;
        doneQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strb.alloc && allocIdx == IDX_W'(i)) begin
          stQ[i]   <= ENT_PEND;
          cntQ[i]  <= CNT_W'(1);
          doneQ[i] <= '0;
        end
        if (strb.merge && mergeIdx == IDX_W'(i)) cntQ[i] <= cntQ[i] + CNT_W'(1);
        if (strb.fill && fillIdx == IDX_W'(i)) stQ[i] <= ENT_FILL;
        if (strb.drain && drainIdx == IDX_W'(i)) begin
          if (drainLast) stQ[i] <= ENT_FREE;
          else           doneQ[i] <= doneQ[i] + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/mafDatapath.sv
module mafDatapath
  import mafPkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int WAITERS = 2,
  parameter int LINE_W  = 26,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [IDX_W-1:0]   allocIdx,
  input  logic [IDX_W-1:0]   mergeIdx,
  input  logic [CNT_W-1:0]   mergeSlot,
  input  logic [IDX_W-1:0]   fillIdx,
  input  logic [IDX_W-1:0]   drainIdx,
  input  logic [CNT_W-1:0]   drainSlot,
  input  logic [LINE_W-1:0]  missLine,
  input  logic [TAG_W-1:0]   missTag,
  input  logic [DATA_W-1:0]  rspData,
  output logic [ENTRIES-1:0] lineHit,
  output logic               reqValid,
  output logic [LINE_W-1:0]  reqLine,
  output logic [IDX_W-1:0]   reqIdx,
  output logic [TAG_W-1:0]   outTag,
  output logic [DATA_W-1:0]  outData
);

  logic [LINE_W-1:0] lineQ [ENTRIES];
  logic [TAG_W-1:0]  tagQ  [ENTRIES][WAITERS];
  logic [DATA_W-1:0] dataQ [ENTRIES];

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gCmp
      assign lineHit[g] = (lineQ[g] == missLine);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.alloc) begin
      lineQ[allocIdx]   <= missLine;
      tagQ[allocIdx][0] <= missTag;
    end
    if (strb.merge) tagQ[mergeIdx][mergeSlot] <= missTag;
    if (strb.fill)  dataQ[fillIdx] <= rspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      reqLine  <= '0;
      reqIdx   <= '0;
    end else begin
      reqValid <= strb.alloc;
      reqLine  <= missLine;
      reqIdx   <= allocIdx;
    end
  end

  assign outTag  = tagQ[drainIdx][drainSlot];
  assign outData = dataQ[drainIdx];

endmodule

// File: rtl/missAddrFile.sv
module missAddrFile
  import mafPkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int WAITERS = 2,
  parameter int LINE_W  = 26,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(WAITERS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [LINE_W-1:0] missLine,
  input  logic [TAG_W-1:0]  missTag,
  output logic              stall,
  output logic              reqValid,
  output logic [LINE_W-1:0] reqLine,
  output logic [IDX_W-1:0]  reqIdx,
  input  logic              rspValid,
  input  logic [IDX_W-1:0]  rspIdx,
  input  logic [DATA_W-1:0] rspData,
  output logic              outValid,
  output logic [TAG_W-1:0]  outTag,
  output logic [DATA_W-1:0] outData
);

  ctrlStrobes_t       strb;
  logic [ENTRIES-1:0] lineHit;
  logic [IDX_W-1:0]   allocIdx, mergeIdx, fillIdx, drainIdx;
  logic [CNT_W-1:0]   mergeSlot, drainSlot;

  mafControl #(
    .ENTRIES(ENTRIES), .WAITERS(WAITERS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .missValid(missValid), .lineHit(lineHit),
    .rspValid(rspValid), .rspIdx(rspIdx), .strb(strb),
    .allocIdx(allocIdx), .mergeIdx(mergeIdx), .mergeSlot(mergeSlot),
    .fillIdx(fillIdx), .drainIdx(drainIdx), .drainSlot(drainSlot),
    .stall(stall), .outValid(outValid)
  );

  mafDatapath #(
    .ENTRIES(ENTRIES), .WAITERS(WAITERS), .LINE_W(LINE_W), .TAG_W(TAG_W),
    .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) i_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocIdx(allocIdx), .mergeIdx(mergeIdx), .mergeSlot(mergeSlot),
    .fillIdx(fillIdx), .drainIdx(drainIdx), .drainSlot(drainSlot),
    .missLine(missLine), .missTag(missTag), .rspData(rspData),
    .lineHit(lineHit), .reqValid(reqValid), .reqLine(reqLine), .reqIdx(reqIdx),
    .outTag(outTag), .outData(outData)
  );

endmodule

// File: rtl/mafChecker.sv
module mafChecker #(
  parameter int ENTRIES = 6,
  parameter int LINE_W  = 26,
  parameter int IDX_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic [LINE_W-1:0] missLine,
  input logic              stall,
  input logic              reqValid,
  input logic [LINE_W-1:0] reqLine,
  input logic [IDX_W-1:0]  reqIdx,
  input logic              rspValid,
  input logic              outValid
);

  AST_STALL_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> missValid); // R4

  AST_REQ_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ($past(missValid && !stall) && reqLine == $past(missLine))); // R2

  AST_REQ_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (int'(reqIdx) < ENTRIES)); // R5

  AST_NO_REPEAT_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && $past(reqValid)) |-> (reqLine != $past(reqLine))); // R3

  AST_OUT_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(rspValid)); // R6

endmodule

bind missAddrFile mafChecker #(
  .ENTRIES(ENTRIES), .LINE_W(LINE_W), .IDX_W(IDX_W)
) i_mafChecker (
  .clk(clk), .rstN(rstN), .missValid(missValid), .missLine(missLine),
  .stall(stall), .reqValid(reqValid), .reqLine(reqLine), .reqIdx(reqIdx),
  .rspValid(rspValid), .outValid(outValid)
);

// File: tb/test_missAddrFile.sv
`timescale 1ns/1ps
module test_missAddrFile;

  localparam int N  = 6;
  localparam int LW = 26;
  localparam int TW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          missValid;
  logic [LW-1:0] missLine;
  logic [TW-1:0] missTag;
  logic          stall, reqValid, outValid;
  logic [LW-1:0] reqLine;
  logic [2:0]    reqIdx;
  logic          rspValid;
  logic [2:0]    rspIdx;
  logic [DW-1:0] rspData;
  logic [TW-1:0] outTag;
  logic [DW-1:0] outData;

  always #4 clk = ~clk;

  missAddrFile i_missAddrFile (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missLine(missLine),
    .missTag(missTag), .stall(stall), .reqValid(reqValid), .reqLine(reqLine),
    .reqIdx(reqIdx), .rspValid(rspValid), .rspIdx(rspIdx), .rspData(rspData),
    .outValid(outValid), .outTag(outTag), .outData(outData)
  );

  int nChecks = 0;
  int nFail   = 0;
  string scn  = "R1 reset";

  // reference model: 0 free, 1 waiting, 2 filled
  int            mSt   [N];
  logic [LW-1:0] mLine [N];
  int            mTags [N][$];
  logic [DW-1:0] mData [N];
  bit            eReqV = 1'b0;
  logic [LW-1:0] eReqLine = '0;
  int            eReqIdx = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s [%s] actual %0h expected %0h", req, scn, act, exp);
    end
  endtask

  task automatic step(bit mv, logic [LW-1:0] ln, logic [TW-1:0] tg,
                      bit rv, logic [2:0] ri, logic [DW-1:0] rd);
    int  hit, freeI, drainI;
    bit  expStall, fillOk, nReqV;
    missValid = mv; missLine = ln; missTag = tg;
    rspValid = rv; rspIdx = ri; rspData = rd;
    #1;
    hit = -1; freeI = -1; drainI = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (mSt[i] == 1 && mLine[i] == ln) hit = i;
      if (mSt[i] == 0) freeI = i;
      if (mSt[i] == 2) drainI = i;
    end
    expStall = mv && ((hit >= 0) ? (mTags[hit].size() >= 2) : (freeI < 0));
    fillOk   = rv && (int'(ri) < N) && (mSt[ri] == 1);

    check("R4 stall", 64'(stall), 64'(expStall));
    check("R2 reqValid", 64'(reqValid), 64'(eReqV));
    if (eReqV) begin
      check("R2 reqLine", 64'(reqLine), 64'(eReqLine));
      check("R2 reqIdx", 64'(reqIdx), 64'(eReqIdx));
    end
    check("R6 outValid", 64'(outValid), 64'(drainI >= 0));
    if (drainI >= 0) begin
      check("R6 outTag", 64'(outTag), 64'(mTags[drainI][0]));
      check("R6 outData", 64'(outData), 64'(mData[drainI]));
    end

    nReqV = 1'b0;
    if (drainI >= 0) begin
      void'(mTags[drainI].pop_front());
      if (mTags[drainI].size() == 0) mSt[drainI] = 0;
    end
    if (mv && !expStall) begin
      if (hit >= 0) mTags[hit].push_back(int'(tg));
      else begin
        mSt[freeI] = 1;
        mLine[freeI] = ln;
        mTags[freeI].delete();
        mTags[freeI].push_back(int'(tg));
        nReqV = 1'b1;
        eReqLine = ln;
        eReqIdx = freeI;
      end
    end
    if (fillOk) begin
      mSt[ri] = 2;
      mData[ri] = rd;
    end
    eReqV = nReqV;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, '0, '0, 0, '0, '0);
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired [%s] actual running expected done", scn);
    finish();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mSt[i] = 0; mLine[i] = '0; mData[i] = '0;
    end
    rstN = 1'b0;
    missValid = 0; missLine = '0; missTag = '0;
    rspValid = 0; rspIdx = '0; rspData = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    check("R1 stall", 64'(stall), 64'(0));
    check("R1 reqValid", 64'(reqValid), 64'(0));
    check("R1 outValid", 64'(outValid), 64'(0));
    rstN = 1'b1;
    idle(1);

    scn = "R2 alloc";
    step(1, 26'h100, 6'd1, 0, 0, 0);
    idle(1);
    scn = "R3 merge";
    step(1, 26'h100, 6'd2, 0, 0, 0);
    scn = "R4 waiters full";
    step(1, 26'h100, 6'd3, 0, 0, 0);
    scn = "R6 deliver in order";
    step(0, '0, '0, 1, 3'd0, 32'hAAAA0001);
    idle(3);

    scn = "R5 six outstanding";
    for (int i = 0; i < N; i++) step(1, 26'h200 + 26'(i), 6'(10 + i), 0, 0, 0);
    scn = "R4 table full";
    step(1, 26'h2FF, 6'd20, 0, 0, 0);

    scn = "R8 ignored response";
    step(0, '0, '0, 1, 3'd6, 32'hDEAD0006);
    step(0, '0, '0, 1, 3'd7, 32'hDEAD0007);
    idle(1);

    scn = "R7 lowest first";
    step(0, '0, '0, 1, 3'd5, 32'h55);
    step(0, '0, '0, 1, 3'd3, 32'h33);
    scn = "R8 refill to filled entry";
    step(0, '0, '0, 1, 3'd3, 32'hBAD3);
    scn = "R7 lowest first";
    step(0, '0, '0, 1, 3'd1, 32'h11);
    idle(4);

    scn = "R9 filled line not merged";
    step(0, '0, '0, 1, 3'd4, 32'h44);
    step(1, 26'h204, 6'd30, 0, 0, 0);
    idle(2);
    scn = "R8 refill to free entry";
    step(0, '0, '0, 1, 3'd4, 32'hBAD4);
    idle(1);
    scn = "R6 drain rest";
    for (int i = 0; i < N; i++) step(0, '0, '0, 1, 3'(i), 32'h900 + 32'(i));
    idle(8);

    scn = "R2 R3 R4 R6 R7 R8 mixed traffic";
    for (int k = 0; k < 4000; k++) begin
      step(1'($urandom % 2), 26'h300 + 26'($urandom % 8), 6'($urandom),
           ($urandom % 3) == 0, 3'($urandom % 8), $urandom);
    end
    idle(20);
    finish();
  end

endmodule